// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a slave on a two-wire serial bus (SMBus-style, up to 100 kbit/s) that holds a small bank of clock-control bytes. A bus master writes the bank with a block write and reads it back with a block read. The block samples the serial clock and data lines with the system clock, detects start and stop conditions, and acknowledges bytes by pulling the data line low through an open-drain enable. The register bank leaves reset with fixed power-up values, and its contents are presented in parallel to the clock logic.

Individual registers cannot be addressed. A write frame carries the device address, then a command byte and a count byte that are acknowledged and then discarded, then data bytes that always fill the bank from register 0 upward. A read frame returns a length byte first, then every register in order. A frame sent to any other address leaves the bank untouched.

Top module: `smbcfg_slave`

## Requirements
- R1: After reset the bank holds 0xF6, 0x3F, 0xE0, 0x7E, 0x00, 0x00 in registers 0 to 5; register i appears on cfg_bytes[8i+7:8i], and sda_oe is 0.
- R2: SDA falling while SCL is high starts a frame, and SDA rising while SCL is high ends it. A stop in the middle of a write keeps the bytes already taken, and the next frame fills the bank again from register 0. sda_oe changes only while SCL is low.
- R3: The device address is 0x69. The address byte 0xD2 (LSB 0) opens a write and 0xD3 (LSB 1) opens a read, and the slave acknowledges that byte by holding SDA low for the ninth clock.
- R4: In a write, the two bytes after the address (command and count) are acknowledged and their values have no effect: the first data byte always lands in register 0, whatever the command value.
- R5: Bits arrive MSB first, and each data byte within the limits is acknowledged on its ninth clock and stored in the next register in sequence.
- R6: Data bytes 7 to 10 of a frame are acknowledged and discarded. The 11th data byte is not acknowledged, and the rest of that frame is ignored.
- R7: A frame whose address byte does not carry address 0x69 gets no acknowledge, never drives SDA, and leaves every register unchanged.
- R8: A read returns the byte 0x06 (number of registers) first, then registers 0 to 5 in order, MSB first. Any byte asked for after register 5 reads 0xFF.
- R9: When the master does not acknowledge a byte it reads, the slave releases SDA and leaves it released until the next start.
- R10: Register 5 is stored whole. Bit 7 selects the spread mode (0 down, 1 centre), bits 6:5 the spread width and bits 1:0 the extended frequency select, each on its own cfg_bytes bits (47, 46:45, 41:40).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset; loads the power-up bank |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain), 0 releases it |
| cfg_bytes | output | 48 | Register bank, register i in bits 8i+7:8i |

## Verification
The assertions take it for granted that each SCL level lasts much longer than the synchronizer delay. They also assume that the master moves SDA only while SCL is low, apart from its own start and stop, and that it never signals a start or stop while the slave pulls SDA low. Under those assumptions the slave's SDA enable can only move in an SCL low phase, and the slave stays silent during data bits it receives, acknowledge slots it reads and ignored frames. The bench master holds each SCL phase for a dozen system clocks and changes SDA two clocks after SCL falls. It resolves the open-drain line as the AND of both sides, so the stimulus stays inside those assumptions.

// File: rtl/smbcfg_pkg.sv
`timescale 1ns/1ps
package smbcfg_pkg;

  typedef enum logic [1:0] {
    MD_IDLE = 2'd0,
    MD_RX   = 2'd1,
    MD_TX   = 2'd2,
    MD_SKIP = 2'd3
  } xfer_mode_e;

  typedef enum logic [1:0] {
    ST_ADDR = 2'd0,
    ST_CMD  = 2'd1,
    ST_CNT  = 2'd2,
    ST_DATA = 2'd3
  } rx_stage_e;

  // Power-up contents of each bank entry
  function automatic logic [7:0] reg_default(input int idx);
    case (idx)
      0:       return 8'hF6;
      1:       return 8'h3F;
      2:       return 8'hE0;
      3:       return 8'h7E;
      default: return 8'h00;
    endcase
  endfunction

  // Address byte carries the 7-bit device address above the direction bit
  function automatic logic addr_hit(input logic [7:0] addr_byte, input logic [6:0] dev);
    return addr_byte[7:1] == dev;
  endfunction

  // Open-drain enable that puts a data bit on the line
  function automatic logic drive_for(input logic bit_val);
    return ~bit_val;
  endfunction

endpackage

// File: rtl/smbcfg_line_sync.sv
`timescale 1ns/1ps
module smbcfg_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int CW = 2 * STAGES;

  logic [CW-1:0] chain_q;
  logic [1:0]    prev_q;
  logic [1:0]    cur;

  // Both lines pass through the same depth so their relative order is kept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[CW-3:0], sda_in, scl_in};
  end

  assign cur = chain_q[CW-1:CW-2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 2'b11;
    else        prev_q <= cur;
  end

  assign scl_s     = cur[0];
  assign sda_s     = cur[1];
  assign scl_rise  =  scl_s & ~prev_q[0];
  assign scl_fall  = ~scl_s &  prev_q[0];
  assign start_det =  scl_s &  prev_q[0] &  prev_q[1] & ~sda_s;
  assign stop_det  =  scl_s &  prev_q[0] & ~prev_q[1] &  sda_s;

endmodule

// File: rtl/smbcfg_regs.sv
`timescale 1ns/1ps
module smbcfg_regs
  import smbcfg_pkg::*;
#(
  parameter int NUM_REGS = 6,
  parameter int IDX_W    = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [7:0]            wr_data,
  input  logic [IDX_W-1:0]      rd_idx,
  output logic [7:0]            rd_data,
  output logic [NUM_REGS*8-1:0] cfg_flat
);

  genvar g;
  generate
    for (g = 0; g < NUM_REGS; g++) begin : g_byte
      logic [7:0] byte_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   byte_q <= reg_default(g);
        else if (wr_en && (wr_idx == IDX_W'(g)))      byte_q <= wr_data;
      end
      assign cfg_flat[g*8 +: 8] = byte_q;
    end
  endgenerate

  // Reads past the last entry return an all-ones (released) byte
  always_comb begin
    rd_data = 8'hFF;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_idx == IDX_W'(i)) rd_data = cfg_flat[i*8 +: 8];
    end
  end

  // R7
  regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(cfg_flat))
    else $error("bank changed without a write strobe");

endmodule

// File: rtl/smbcfg_frame.sv
`timescale 1ns/1ps
module smbcfg_frame
  import smbcfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         NUM_REGS = 6,
  parameter int         MAX_DATA = 10,
  parameter int         CNT_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_s,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [7:0]       rd_data,
  output logic             sda_oe,
  output logic             wr_en,
  output logic [CNT_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic [CNT_W-1:0] rd_idx
);
  localparam logic [7:0] COUNT_BYTE = 8'(NUM_REGS);
  localparam logic [3:0] BIT_ACK    = 4'd8;
  localparam logic [3:0] BIT_DONE   = 4'd9;

  xfer_mode_e       mode_q;
  rx_stage_e        stage_q;
  logic [3:0]       bit_cnt_q;
  logic [7:0]       shift_q;
  logic             rw_q;
  logic             master_ack_q;
  logic             sda_oe_q;
  logic [CNT_W-1:0] data_cnt_q;
  logic [CNT_W-1:0] tx_idx_q;

  // Named events
  logic rx_bit, byte_done, ack_end, addr_match, data_room, data_kept;
  logic tx_shift_ev, tx_release_ev, tx_ack_ev, tx_next_ev;

  assign rx_bit        = (mode_q == MD_RX) & scl_rise & (bit_cnt_q < BIT_ACK);
  assign byte_done     = (mode_q == MD_RX) & scl_fall & (bit_cnt_q == BIT_ACK);
  assign ack_end       = (mode_q == MD_RX) & scl_fall & (bit_cnt_q == BIT_DONE);
  assign addr_match    = addr_hit(shift_q, DEV_ADDR);
  assign data_room     = data_cnt_q < CNT_W'(MAX_DATA);
  assign data_kept     = data_cnt_q < CNT_W'(NUM_REGS);
  assign tx_shift_ev   = (mode_q == MD_TX) & scl_fall & (bit_cnt_q >= 4'd1) & (bit_cnt_q <= 4'd7);
  assign tx_release_ev = (mode_q == MD_TX) & scl_fall & (bit_cnt_q == BIT_ACK);
  assign tx_ack_ev     = (mode_q == MD_TX) & scl_rise & (bit_cnt_q == BIT_ACK);
  assign tx_next_ev    = (mode_q == MD_TX) & scl_fall & (bit_cnt_q == BIT_DONE);

  assign wr_en   = byte_done & (stage_q == ST_DATA) & data_room & data_kept;
  assign wr_idx  = data_cnt_q;
  assign wr_data = shift_q;
  assign rd_idx  = tx_idx_q;
  assign sda_oe  = sda_oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q       <= MD_IDLE;
      stage_q      <= ST_ADDR;
      bit_cnt_q    <= '0;
      shift_q      <= '0;
      rw_q         <= 1'b0;
      master_ack_q <= 1'b0;
      sda_oe_q     <= 1'b0;
      data_cnt_q   <= '0;
      tx_idx_q     <= '0;
    end else if (start_det) begin
      mode_q     <= MD_RX;
      stage_q    <= ST_ADDR;
      bit_cnt_q  <= '0;
      sda_oe_q   <= 1'b0;
      data_cnt_q <= '0;
      tx_idx_q   <= '0;
    end else if (stop_det) begin
      mode_q    <= MD_IDLE;
      bit_cnt_q <= '0;
      sda_oe_q  <= 1'b0;
    end else begin
      case (mode_q)
        MD_RX: begin
          if (rx_bit) begin
            shift_q   <= {shift_q[6:0], sda_s};
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (byte_done) begin
            if (stage_q == ST_ADDR) begin
              if (addr_match) begin
                sda_oe_q  <= 1'b1;
                rw_q      <= shift_q[0];
                bit_cnt_q <= BIT_DONE;
              end else begin
                mode_q <= MD_SKIP;
              end
            end else if ((stage_q == ST_DATA) && !data_room) begin
              mode_q <= MD_SKIP;
            end else begin
              sda_oe_q  <= 1'b1;
              bit_cnt_q <= BIT_DONE;
              if (stage_q == ST_DATA) data_cnt_q <= data_cnt_q + CNT_W'(1);
            end
          end else if (ack_end) begin
            bit_cnt_q <= '0;
            if ((stage_q == ST_ADDR) && rw_q) begin
              mode_q   <= MD_TX;
              shift_q  <= COUNT_BYTE;
              sda_oe_q <= drive_for(COUNT_BYTE[7]);
            end else begin
              sda_oe_q <= 1'b0;
              if (stage_q != ST_DATA) stage_q <= rx_stage_e'(stage_q + 2'd1);
            end
          end
        end
        MD_TX: begin
          if (scl_rise && (bit_cnt_q < BIT_ACK)) begin
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (tx_ack_ev) begin
            master_ack_q <= ~sda_s;
            bit_cnt_q    <= BIT_DONE;
          end else if (tx_shift_ev) begin
            shift_q  <= {shift_q[6:0], 1'b0};
            sda_oe_q <= drive_for(shift_q[6]);
          end else if (tx_release_ev) begin
            sda_oe_q <= 1'b0;
          end else if (tx_next_ev) begin
            if (master_ack_q) begin
              shift_q   <= rd_data;
              sda_oe_q  <= drive_for(rd_data[7]);
              bit_cnt_q <= '0;
              if (tx_idx_q < CNT_W'(NUM_REGS)) tx_idx_q <= tx_idx_q + CNT_W'(1);
            end else begin
              mode_q   <= MD_SKIP;
              sda_oe_q <= 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R2
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sda_oe_q != $past(sda_oe_q)) && !$past(start_det) && !$past(stop_det)) |-> !scl_s)
    else $error("SDA enable moved while SCL high");

  // R7
  skip_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_SKIP) |-> !sda_oe_q)
    else $error("SDA driven in an ignored frame");

  // R5
  rx_bits_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MD_RX) && (bit_cnt_q < BIT_ACK)) |-> !sda_oe_q)
    else $error("SDA driven while the master sends bits");

  // R9
  tx_ack_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MD_TX) && (bit_cnt_q == BIT_DONE)) |-> !sda_oe_q)
    else $error("SDA driven in the master acknowledge slot");

endmodule

// File: rtl/smbcfg_slave.sv
`timescale 1ns/1ps
module smbcfg_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         NUM_REGS    = 6,
  parameter int         MAX_DATA    = 10,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_in,
  input  logic                  sda_in,
  output logic                  sda_oe,
  output logic [NUM_REGS*8-1:0] cfg_bytes
);
  localparam int TOP_CNT = (MAX_DATA > NUM_REGS) ? MAX_DATA : NUM_REGS;
  localparam int CNT_W   = $clog2(TOP_CNT + 1);

  logic             scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic             wr_en;
  logic [CNT_W-1:0] wr_idx, rd_idx;
  logic [7:0]       wr_data, rd_data;

  smbcfg_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  smbcfg_frame #(
    .DEV_ADDR (DEV_ADDR),
    .NUM_REGS (NUM_REGS),
    .MAX_DATA (MAX_DATA),
    .CNT_W    (CNT_W)
  ) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rd_data   (rd_data),
    .sda_oe    (sda_oe),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .rd_idx    (rd_idx)
  );

  smbcfg_regs #(
    .NUM_REGS (NUM_REGS),
    .IDX_W    (CNT_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .rd_idx   (rd_idx),
    .rd_data  (rd_data),
    .cfg_flat (cfg_bytes)
  );

endmodule

// File: tb/smbcfg_slave_bench.sv
`timescale 1ns/1ps
module smbcfg_slave_bench;
  localparam int Q        = 12;
  localparam int NREG     = 6;
  localparam int WATCHDOG = 150000;

  // {address byte, data byte count, seed}; data k = seed + k*0x11
  localparam logic [19:0] VEC [8] = '{
    {8'hD2, 4'd6, 8'h10},
    {8'hD2, 4'd3, 8'hA0},
    {8'hD0, 4'd4, 8'h55},
    {8'hD2, 4'd1, 8'hC3},
    {8'hA4, 4'd6, 8'h00},
    {8'hD2, 4'd5, 8'h21},
    {8'hD3, 4'd2, 8'hF0},
    {8'hD2, 4'd6, 8'h07}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda_low = 1'b0;
  logic sda_line;
  logic sda_oe;
  logic [NREG*8-1:0] cfg_bytes;

  logic [7:0] wbuf  [16];
  logic [7:0] model [NREG];
  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  assign sda_line = ~(m_sda_low | sda_oe);

  smbcfg_slave u_smbcfg_slave (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (m_scl),
    .sda_in    (sda_line),
    .sda_oe    (sda_oe),
    .cfg_bytes (cfg_bytes)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [NREG*8-1:0] model_flat();
    logic [NREG*8-1:0] f;
    for (int i = 0; i < NREG; i++) f[i*8 +: 8] = model[i];
    return f;
  endfunction

  task automatic bus_start();
    m_sda_low = 1'b0; m_scl = 1'b1; tick(Q);
    m_sda_low = 1'b1; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda_low = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda_low = 1'b0; tick(Q);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda_low = ~b[i]; tick(Q);
      m_scl = 1'b1; tick(Q);
      m_scl = 1'b0; tick(2);
    end
    m_sda_low = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q/2);
    ack = ~sda_line;
    tick(Q/2);
    m_scl = 1'b0; tick(2);
  endtask

  task automatic get_byte(input logic give_ack, output logic [7:0] b);
    m_sda_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      m_scl = 1'b1; tick(Q/2);
      b[i] = sda_line;
      tick(Q/2);
      m_scl = 1'b0; tick(2);
    end
    m_sda_low = give_ack; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_scl = 1'b0; tick(2);
    m_sda_low = 1'b0;
  endtask

  // Ack bits: [0] address, [1] command, [2] count, [3+k] data byte k
  task automatic write_frame(input logic [7:0] addr, input logic [7:0] cmd, input int n,
                             input logic send_stop, output logic [15:0] acks);
    logic a;
    acks = '0;
    bus_start();
    put_byte(addr, a);    acks[0] = a;
    put_byte(cmd, a);     acks[1] = a;
    put_byte(8'(n), a);   acks[2] = a;
    for (int k = 0; k < n; k++) begin
      put_byte(wbuf[k], a);
      acks[3+k] = a;
    end
    if (send_stop) bus_stop();
  endtask

  task automatic model_take(input int n);
    for (int k = 0; k < n && k < NREG && k < 10; k++) model[k] = wbuf[k];
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected completion earlier", WATCHDOG);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] acks;
    logic [15:0] exp_acks;
    logic [7:0]  rb;
    logic        a;
    logic [7:0]  ad;
    int          n;
    logic [7:0]  seed;

    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    model[0] = 8'hF6; model[1] = 8'h3F; model[2] = 8'hE0; model[3] = 8'h7E;

    tick(5);
    rst_n = 1'b1;
    tick(5);
    // R1 reset state
    check("R1 reset bank", 64'(cfg_bytes), 64'(48'h0000_7EE0_3FF6));
    check("R1 reset sda_oe", 64'(sda_oe), 64'd0);

    // Table walk: R3 address decode, R5 sequential load, R7 foreign address
    for (int i = 0; i < 8; i++) begin
      ad   = VEC[i][19:12];
      n    = int'(VEC[i][11:8]);
      seed = VEC[i][7:0];
      for (int k = 0; k < n; k++) wbuf[k] = seed + 8'(k) * 8'h11;
      write_frame(ad, 8'h00, n, 1'b1, acks);
      tick(4);
      if (ad == 8'hD2) begin
        exp_acks = 16'((32'd1 << (3 + n)) - 1);
        model_take(n);
        check("R3 R5 write acks", 64'(acks), 64'(exp_acks));
        check("R5 bank after write", 64'(cfg_bytes), 64'(model_flat()));
      end else if (ad == 8'hD3) begin
        // read address: slave acks address then transmits; master wrote over it
        check("R3 read address ack", 64'(acks[0]), 64'd1);
        check("R7 bank kept after read frame", 64'(cfg_bytes), 64'(model_flat()));
      end else begin
        check("R7 foreign address no ack", 64'(acks), 64'd0);
        check("R7 bank kept", 64'(cfg_bytes), 64'(model_flat()));
      end
    end

    // R4: command value 5 and count 0x99 do not steer the write
    wbuf[0] = 8'h9C;
    bus_start();
    put_byte(8'hD2, a);
    put_byte(8'h05, a); check("R4 command acked", 64'(a), 64'd1);
    put_byte(8'h99, a); check("R4 count acked", 64'(a), 64'd1);
    put_byte(wbuf[0], a);
    bus_stop();
    tick(4);
    model[0] = 8'h9C;
    check("R4 data lands in register 0", 64'(cfg_bytes), 64'(model_flat()));

    // R10: register 5 fields
    for (int k = 0; k < 6; k++) wbuf[k] = 8'h40 + 8'(k);
    wbuf[5] = 8'hC2;
    write_frame(8'hD2, 8'h00, 6, 1'b1, acks);
    tick(4);
    model_take(6);
    check("R10 spread mode bit", 64'(cfg_bytes[47]), 64'd1);
    check("R10 spread width", 64'(cfg_bytes[46:45]), 64'd2);
    check("R10 extended select", 64'(cfg_bytes[41:40]), 64'd2);

    // R6: eight data bytes all acked, only six stored
    for (int k = 0; k < 8; k++) wbuf[k] = 8'h80 + 8'(k) * 8'h03;
    write_frame(8'hD2, 8'h00, 8, 1'b1, acks);
    tick(4);
    model_take(8);
    check("R6 eight bytes acked", 64'(acks), 64'h07FF);
    check("R6 extra bytes discarded", 64'(cfg_bytes), 64'(model_flat()));

    // R6: eleventh data byte refused
    for (int k = 0; k < 11; k++) wbuf[k] = 8'h11 * 8'(k + 1);
    write_frame(8'hD2, 8'h00, 11, 1'b1, acks);
    tick(4);
    model_take(11);
    check("R6 eleventh byte not acked", 64'(acks), 64'h1FFF);
    check("R6 bank after long frame", 64'(cfg_bytes), 64'(model_flat()));

    // R2: stop after two data bytes, then a fresh frame restarts at register 0
    wbuf[0] = 8'h5A; wbuf[1] = 8'hA5;
    write_frame(8'hD2, 8'h00, 2, 1'b1, acks);
    tick(4);
    model_take(2);
    check("R2 partial frame kept", 64'(cfg_bytes), 64'(model_flat()));
    wbuf[0] = 8'h3C;
    write_frame(8'hD2, 8'h00, 1, 1'b1, acks);
    tick(4);
    model_take(1);
    check("R2 new frame restarts at 0", 64'(cfg_bytes), 64'(model_flat()));

    // R8: block read
    bus_start();
    put_byte(8'hD3, a);
    check("R3 read address acked", 64'(a), 64'd1);
    get_byte(1'b1, rb);
    check("R8 length byte", 64'(rb), 64'h06);
    for (int i = 0; i < NREG; i++) begin
      get_byte(1'b1, rb);
      check("R8 register readback", 64'(rb), 64'(model[i]));
    end
    get_byte(1'b0, rb);
    check("R8 past last register", 64'(rb), 64'hFF);
    bus_stop();
    tick(4);

    // R9: master refuses the length byte, slave then stays released
    bus_start();
    put_byte(8'hD3, a);
    get_byte(1'b0, rb);
    check("R9 length before nack", 64'(rb), 64'h06);
    get_byte(1'b1, rb);
    check("R9 line released after nack", 64'(rb), 64'hFF);
    check("R9 sda_oe idle", 64'(sda_oe), 64'd0);
    bus_stop();
    tick(4);

    // R7: read direction to a foreign address
    bus_start();
    put_byte(8'hD5, a);
    check("R7 foreign read no ack", 64'(a), 64'd0);
    get_byte(1'b0, rb);
    check("R7 foreign read released", 64'(rb), 64'hFF);
    bus_stop();
    tick(4);
    check("R7 bank unchanged at end", 64'(cfg_bytes), 64'(model_flat()));

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule